// File: doc/BRIEF.md
# Display Scanout Address Generator

This block produces the frame-buffer read addresses that a raster display engine needs, one scan line at a time. A start-of-frame event loads a programmed start offset and clears the output line count. Each start-of-line event fixes the base address of the new line and launches a fixed-length burst of DWORD fetch addresses, each one marked by a valid strobe.

Three legacy-compatibility options change the address pattern:
- **Split screen** forces the line base back to zero on a chosen output line.
- **Line doubling** lets each pair of output lines share one frame-buffer line and flags the second line of the pair as a repeat.
- **Chain-4 skip** makes the burst step four DWORDs per fetch instead of one.

The block's outputs feed a fetch queue. Pixel formatting and sync timing belong to other blocks.

Top module: `scanout_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `fetch_valid` is 0, `repeat_line` is 0 and `fetch_addr` is 0.
- R2: The first `line_sol` after a `frame_sof` uses `start_offset` as its line base, and that line is output line 0.
- R3: With doubling and split screen off, each later `line_sol` sets the line base to the previous base plus `stride`, modulo 2^ADDR_W.
- R4: A `line_sol` is sampled on a clock edge. Starting at that edge, `fetch_valid` is high for exactly FETCHES cycles, and then low until the next line start. The first `fetch_addr` of the burst is the line base.
- R5: Within a burst, `fetch_addr` rises by 4 per cycle when `chain4_en` was 1 at the line start, and by 1 per cycle when it was 0, modulo 2^ADDR_W.
- R6: With `dbl_en` set, a line start that makes the output line count odd keeps the previous line base. A line start that makes the count even adds `stride`.
- R7: `repeat_line` is set for a line only when `dbl_en` was 1 at its start and the new output line count is odd. Otherwise it is 0.
- R8: With `split_en` set, a line whose output line count equals `split_line` gets base 0, and later lines advance from 0. This count is the output line count, even while doubling is on. Split screen takes priority over the doubling hold.
- R9: `frame_sof` wins over a `line_sol` sampled in the same cycle. It ends any burst, so `fetch_valid` is 0 on the next cycle, and it clears `repeat_line`.
- R10: A `line_sol` that arrives during a burst abandons the rest of that burst. A new full burst starts from the new line base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sof | input | 1 | Start-of-frame pulse |
| line_sol | input | 1 | Start-of-line pulse |
| start_offset | input | ADDR_W | DWORD address of the first line of the frame |
| stride | input | ADDR_W | DWORD distance between frame-buffer lines |
| split_line | input | LINE_W | Output line on which the base returns to zero |
| split_en | input | 1 | Enables split screen |
| dbl_en | input | 1 | Enables line doubling |
| chain4_en | input | 1 | Selects a step of 4 DWORDs per fetch |
| fetch_addr | output | ADDR_W | DWORD fetch address |
| fetch_valid | output | 1 | `fetch_addr` is a fetch this cycle |
| repeat_line | output | 1 | Current output line repeats the previous one |

## Verification
A corrupted line base shows up on the first fetch address of the next burst, one cycle after the line start. Every address in that burst is then offset by the same amount, and so are all later lines until the next frame start or split-screen hit.

A wrong output line count shows in two places. The `repeat_line` polarity goes wrong at the following line start. A split-screen reset lands on the wrong line, which is visible within a single line time.

A fault in the burst counter or step register shows within one burst: the valid strobe is too long or too short, or the address spacing is wrong. For these reasons the outputs are compared against a model on every clock.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int STEP_W = 3;

  function automatic logic [STEP_W-1:0] fetch_step(input logic chain4);
    return chain4 ? 3'd4 : 3'd1;
  endfunction
endpackage

// File: rtl/scan_line_tracker.sv
module scan_line_tracker #(
  parameter int ADDR_W = 20,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sof,
  input  logic              line_sol,
  input  logic [ADDR_W-1:0] start_offset,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LINE_W-1:0] split_line,
  input  logic              split_en,
  input  logic              dbl_en,
  output logic              line_start,
  output logic [ADDR_W-1:0] nxt_base,
  output logic              repeat_line
);
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] nxt_cnt;
  logic [ADDR_W-1:0] line_base;
  logic              started;
  logic              hold;
  logic              split_hit;

  assign line_start = line_sol & ~frame_sof;

  always_comb begin
    nxt_cnt   = started ? line_cnt + 1'b1 : '0;
    hold      = dbl_en & nxt_cnt[0];
    split_hit = split_en & (nxt_cnt == split_line);
    if (split_hit)
      nxt_base = '0;
    else if (!started || hold)
      nxt_base = line_base;
    else
      nxt_base = line_base + stride;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt    <= '0;
      line_base   <= '0;
      started     <= 1'b0;
      repeat_line <= 1'b0;
    end else if (frame_sof) begin
      line_cnt    <= '0;
      line_base   <= start_offset;
      started     <= 1'b0;
      repeat_line <= 1'b0;
    end else if (line_sol) begin
      line_cnt    <= nxt_cnt;
      line_base   <= nxt_base;
      started     <= 1'b1;
      repeat_line <= hold;
    end
  end

  // R7: no repeat flag on a line begun without doubling
  p_no_repeat_r7: assert property (@(posedge clk) disable iff (rst)
    (line_start && !dbl_en) |=> !repeat_line);

  // R9: frame start clears the repeat flag
  p_sof_clears_r9: assert property (@(posedge clk) disable iff (rst)
    frame_sof |=> (!repeat_line && !started));

  // R6: the second line of a doubled pair keeps the base
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (line_start && started && dbl_en && !line_cnt[0] &&
     !(split_en && (line_cnt + 1'b1) == split_line))
    |=> (line_base == $past(line_base)));

  // R8: a split-screen hit on the output line count zeroes the base
  p_split_r8: assert property (@(posedge clk) disable iff (rst)
    (line_start && started && split_en && (line_cnt + 1'b1) == split_line)
    |=> (line_base == '0));
endmodule

// File: rtl/scan_fetch_seq.sv
module scan_fetch_seq
  import scan_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int FETCHES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sof,
  input  logic              line_start,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              chain4_en,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid
);
  localparam int LEFT_W = (FETCHES > 1) ? $clog2(FETCHES) : 1;
  localparam logic [LEFT_W-1:0] LAST = LEFT_W'(FETCHES - 1);

  logic [LEFT_W-1:0] left;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr  <= '0;
      fetch_valid <= 1'b0;
      left        <= '0;
      step_q      <= '0;
    end else if (frame_sof) begin
      fetch_valid <= 1'b0;
      left        <= '0;
    end else if (line_start) begin
      fetch_addr  <= base_in;
      fetch_valid <= 1'b1;
      left        <= LAST;
      step_q      <= fetch_step(chain4_en);
    end else if (fetch_valid) begin
      if (left == '0) begin
        fetch_valid <= 1'b0;
      end else begin
        fetch_addr <= fetch_addr + ADDR_W'(step_q);
        left       <= left - 1'b1;
      end
    end
  end

  // R5: address spacing inside a burst
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && left != '0 && !line_start && !frame_sof)
    |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(step_q)));

  // R4: burst ends after its last fetch
  p_burst_end_r4: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && left == '0 && !line_start && !frame_sof) |=> !fetch_valid);

  // R9: frame start stops fetching
  p_sof_idle_r9: assert property (@(posedge clk) disable iff (rst)
    frame_sof |=> !fetch_valid);

  // R10: a line start always yields a fetch from the new base
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (fetch_valid && fetch_addr == $past(base_in)));
endmodule

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen #(
  parameter int ADDR_W  = 20,
  parameter int LINE_W  = 11,
  parameter int FETCHES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sof,
  input  logic              line_sol,
  input  logic [ADDR_W-1:0] start_offset,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LINE_W-1:0] split_line,
  input  logic              split_en,
  input  logic              dbl_en,
  input  logic              chain4_en,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic              repeat_line
);
  logic              line_start;
  logic [ADDR_W-1:0] nxt_base;

  scan_line_tracker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_track (
    .clk(clk), .rst(rst), .frame_sof(frame_sof), .line_sol(line_sol),
    .start_offset(start_offset), .stride(stride), .split_line(split_line),
    .split_en(split_en), .dbl_en(dbl_en), .line_start(line_start),
    .nxt_base(nxt_base), .repeat_line(repeat_line)
  );

  scan_fetch_seq #(.ADDR_W(ADDR_W), .FETCHES(FETCHES)) u_fetch (
    .clk(clk), .rst(rst), .frame_sof(frame_sof), .line_start(line_start),
    .base_in(nxt_base), .chain4_en(chain4_en),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid)
  );

  // R1: quiet outputs right after reset
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!fetch_valid && !repeat_line && fetch_addr == '0));
endmodule

// File: tb/scanout_addr_gen_bench.sv
module scanout_addr_gen_bench;
  localparam int ADDR_W  = 20;
  localparam int LINE_W  = 11;
  localparam int FETCHES = 8;
  localparam longint MASK = (64'd1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_sof = 1'b0, line_sol = 1'b0;
  logic [ADDR_W-1:0] start_offset = '0, stride = '0;
  logic [LINE_W-1:0] split_line = '0;
  logic split_en = 1'b0, dbl_en = 1'b0, chain4_en = 1'b0;
  logic [ADDR_W-1:0] fetch_addr;
  logic fetch_valid, repeat_line;

  always #10 clk = ~clk;

  scanout_addr_gen #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .FETCHES(FETCHES)) u_scanout_addr_gen (
    .clk(clk), .rst(rst), .frame_sof(frame_sof), .line_sol(line_sol),
    .start_offset(start_offset), .stride(stride), .split_line(split_line),
    .split_en(split_en), .dbl_en(dbl_en), .chain4_en(chain4_en),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .repeat_line(repeat_line)
  );

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference state
  longint m_base = 0, m_addr = 0;
  int m_cnt = 0, m_left = 0, m_step = 1;
  bit m_started = 0, m_valid = 0, m_rep = 0;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_base = 0; m_addr = 0; m_cnt = 0; m_left = 0; m_step = 1;
      m_started = 0; m_valid = 0; m_rep = 0;
    end else if (frame_sof) begin
      m_cnt = 0; m_base = start_offset; m_started = 0; m_rep = 0;
      m_valid = 0; m_left = 0;
    end else if (line_sol) begin
      int n;
      n = m_started ? (m_cnt + 1) % (1 << LINE_W) : 0;
      if (split_en && n == split_line) m_base = 0;
      else if (m_started && !(dbl_en && (n % 2 == 1))) m_base = (m_base + stride) & MASK;
      m_cnt = n; m_started = 1; m_rep = dbl_en && (n % 2 == 1);
      m_valid = 1; m_addr = m_base; m_left = FETCHES - 1;
      m_step = chain4_en ? 4 : 1;
    end else if (m_valid) begin
      if (m_left == 0) m_valid = 0;
      else begin m_addr = (m_addr + m_step) & MASK; m_left--; end
    end
  endtask

  task automatic cyc(bit s_f, bit s_l);
    frame_sof = s_f; line_sol = s_l;
    model_step();
    @(negedge clk);
    cycles++;
    chk("fetch_valid", fetch_valid, m_valid);
    chk("repeat_line", repeat_line, m_rep);
    chk("fetch_addr", fetch_addr, m_addr);
    frame_sof = 1'b0; line_sol = 1'b0;
  endtask

  task automatic one_line(int len);
    cyc(0, 1);
    for (int i = 1; i < len; i++) cyc(0, 0);
  endtask

  // watchdog
  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1";
    cyc(0, 0); cyc(0, 0);
    rst = 1'b0;
    cyc(0, 0); cyc(0, 0);

    tag = "R2";
    start_offset = 20'h01000; stride = 20'd80;
    cyc(1, 0);
    one_line(12);
    tag = "R3";
    for (int l = 0; l < 4; l++) one_line(12);

    tag = "R5";
    chain4_en = 1'b1;
    for (int l = 0; l < 2; l++) one_line(11);
    chain4_en = 1'b0;

    tag = "R6";
    dbl_en = 1'b1;
    cyc(1, 0);
    for (int l = 0; l < 3; l++) one_line(10);
    tag = "R7";
    for (int l = 0; l < 3; l++) one_line(10);
    dbl_en = 1'b0;
    one_line(10);

    tag = "R8";
    split_en = 1'b1; split_line = 11'd3;
    cyc(1, 0);
    for (int l = 0; l < 6; l++) one_line(9);
    dbl_en = 1'b1; split_line = 11'd5;
    cyc(1, 0);
    for (int l = 0; l < 8; l++) one_line(9);
    split_en = 1'b0; dbl_en = 1'b0;

    tag = "R4";
    start_offset = 20'hFFFF8; stride = 20'd16; chain4_en = 1'b1;
    cyc(1, 0);
    for (int l = 0; l < 3; l++) one_line(FETCHES + 4);
    chain4_en = 1'b0;

    tag = "R9";
    one_line(3);
    cyc(1, 0); cyc(0, 0);
    cyc(1, 1); cyc(0, 0);
    one_line(4);
    dbl_en = 1'b1; one_line(2); one_line(2);
    cyc(1, 0); cyc(0, 0);
    dbl_en = 1'b0;

    tag = "R10";
    one_line(4); one_line(3); one_line(12);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule